// File: doc/BRIEF.md
# RAM Segment Address Sequencer

This block produces the read address for a 10-bit-addressed waveform RAM and walks it across a programmed segment of that RAM. A 48-bit configuration word gives the first and last address of the segment, the pacing between steps in sync-clock cycles, and a 3-bit code that picks the walk pattern. The patterns are a static address, one upward ramp, one ramp up and back down, an endless up/down ping-pong, and an endless upward ramp that wraps back to the start.

A start strobe takes a snapshot of the configuration word and loads the first address. A programmable interval timer then paces every later step. Each new address comes with a one-cycle valid strobe. The one-shot patterns raise a done flag when they finish. When the enable input is low, as in single-tone operation, the block freezes in place. One instance drives one channel.

Top module: `ram_seg_seq`

## Requirements
- R1: While reset is asserted and until the first start, `addr_o` is 0, `addr_vld_o` is 0 and `done_o` is 0.
- R2: A start strobe with `en_i` high loads the beginning address and pulses `addr_vld_o` in the following cycle. It also clears `done_o` and sets the walk direction to upward.
- R3: Consecutive steps are exactly N clock cycles apart, where N is the step interval field. The first step comes N cycles after the load. An interval of 0 behaves as 1.
- R4: Mode code 3'b000 holds the beginning address with no further valid pulses. The codes 3'b101, 3'b110 and 3'b111 behave the same way.
- R5: Mode 3'b001 steps upward by one until it reaches the final address. `done_o` rises in the same cycle that the final address appears, and the address then holds.
- R6: Mode 3'b010 steps up to the final address and then down to the beginning address. `done_o` rises with the return to the beginning address, and the address then holds.
- R7: Mode 3'b011 keeps stepping up and down between the two addresses without end. It turns around at each end.
- R8: Mode 3'b100 steps upward, and after the final address its next step goes to the beginning address. This repeats without end.
- R9: While `en_i` is low, the address, direction, timer and flags are frozen, no valid pulse occurs, and a start strobe is ignored. Raising `en_i` resumes from the frozen state.
- R10: If the beginning address exceeds the final address, the sequencer holds at the beginning address in every mode, with `done_o` low.
- R11: Fields are taken from the word as follows: interval from bits 47:32, final address from bits 31:22, beginning address from bits 15:6, mode from bits 2:0. Bits 21:16 and 5:3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | High in modulation operation, low in single-tone operation |
| start_i | input | 1 | Start/reload strobe, one cycle |
| cfg_i | input | 48 | Segment configuration word |
| addr_o | output | 10 | Current RAM read address |
| addr_vld_o | output | 1 | One-cycle pulse with each load or step |
| done_o | output | 1 | One-shot walk finished |

## Verification
A wrong direction bit shows at the ports at the next step, one interval later: the address moves the wrong way, or a one-shot walk never raises done. A corrupted interval counter shows as a wrong gap between two valid pulses, which the scoreboard measures against the programmed interval on every step. A stale configuration snapshot or a missed freeze shows as an unexpected value or an extra pulse. Such faults appear within a single interval of the load or of the re-enable.

// File: rtl/ram_seg_pkg.sv
package ram_seg_pkg;

  localparam int ADDR_W   = 10;
  localparam int INTV_W   = 16;
  localparam int MODE_W   = 3;
  localparam int CFG_W    = 48;
  localparam int INTV_LSB = 32;
  localparam int FIN_LSB  = 22;
  localparam int BEG_LSB  = 6;
  localparam int MODE_LSB = 0;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT   = 3'b000,
    MODE_UP       = 3'b001,
    MODE_BOUNCE   = 3'b010,
    MODE_PINGPONG = 3'b011,
    MODE_WRAP     = 3'b100
  } walk_mode_e;

  typedef struct packed {
    logic [INTV_W-1:0] intv;
    logic [ADDR_W-1:0] fin;
    logic [ADDR_W-1:0] beg;
    walk_mode_e        mode;
  } seg_cfg_t;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/seg_cfg_decode.sv
module seg_cfg_decode
  import ram_seg_pkg::*;
(
  input  logic [CFG_W-1:0] word_i,
  output seg_cfg_t         cfg_o
);

  logic [MODE_W-1:0] mode_raw;
  logic              unused_bits;

  assign mode_raw    = word_i[MODE_LSB +: MODE_W];
  assign unused_bits = ^{word_i[FIN_LSB-1:BEG_LSB+ADDR_W], word_i[BEG_LSB-1:MODE_LSB+MODE_W]};

  always_comb begin
    cfg_o.intv = word_i[INTV_LSB +: INTV_W];
    cfg_o.fin  = word_i[FIN_LSB  +: ADDR_W];
    cfg_o.beg  = word_i[BEG_LSB  +: ADDR_W];
    case (mode_raw)
      3'b001:  cfg_o.mode = MODE_UP;
      3'b010:  cfg_o.mode = MODE_BOUNCE;
      3'b011:  cfg_o.mode = MODE_PINGPONG;
      3'b100:  cfg_o.mode = MODE_WRAP;
      default: cfg_o.mode = MODE_DIRECT;
    endcase
  end

endmodule

// File: rtl/seg_step_timer.sv
module seg_step_timer #(
  parameter int INTV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [INTV_W-1:0] intv_i,
  output logic              tick_o
);

  logic [INTV_W-1:0] cnt_q, cnt_d, lim;

  assign lim    = (intv_i == '0) ? '0 : intv_i - 1'b1;
  assign tick_o = run_i && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (run_i) cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim));

endmodule

// File: rtl/seg_addr_walker.sv
module seg_addr_walker
  import ram_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  input  seg_cfg_t          cfg_i,
  input  logic              tick_i,
  output logic              load_o,
  output logic              active_o,
  output logic [INTV_W-1:0] intv_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o,
  output logic              done_o
);

  seg_cfg_t          cfg_q, cfg_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_inc, addr_dec;
  logic              dir_q, dir_d;
  logic              done_q, done_d;
  logic              vld_q, vld_d;
  logic              run_q, run_d;
  logic              walk_mode, seg_ok, load, active;

  assign load      = en_i && start_i;
  assign walk_mode = (cfg_q.mode == MODE_UP) || (cfg_q.mode == MODE_BOUNCE) ||
                     (cfg_q.mode == MODE_PINGPONG) || (cfg_q.mode == MODE_WRAP);
  assign seg_ok    = cfg_q.beg <= cfg_q.fin;
  assign active    = en_i && run_q && walk_mode && seg_ok && !done_q && !load;
  assign addr_inc  = addr_q + 1'b1;
  assign addr_dec  = addr_q - 1'b1;

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    dir_d  = dir_q;
    done_d = done_q;
    run_d  = run_q;
    vld_d  = 1'b0;
    if (load) begin
      cfg_d  = cfg_i;
      addr_d = cfg_i.beg;
      dir_d  = 1'b0;
      done_d = ((cfg_i.mode == MODE_UP) || (cfg_i.mode == MODE_BOUNCE)) &&
               (cfg_i.beg == cfg_i.fin);
      run_d  = 1'b1;
      vld_d  = 1'b1;
    end else if (active && tick_i) begin
      vld_d = 1'b1;
      case (cfg_q.mode)
        MODE_UP: begin
          addr_d = addr_inc;
          if (addr_inc == cfg_q.fin) done_d = 1'b1;
        end
        MODE_BOUNCE: begin
          if (!dir_q) begin
            addr_d = addr_inc;
            if (addr_inc == cfg_q.fin) dir_d = 1'b1;
          end else begin
            addr_d = addr_dec;
            if (addr_dec == cfg_q.beg) done_d = 1'b1;
          end
        end
        MODE_PINGPONG: begin
          if (cfg_q.beg == cfg_q.fin) begin
            addr_d = addr_q;
          end else if (!dir_q) begin
            addr_d = addr_inc;
            if (addr_inc == cfg_q.fin) dir_d = 1'b1;
          end else begin
            addr_d = addr_dec;
            if (addr_dec == cfg_q.beg) dir_d = 1'b0;
          end
        end
        MODE_WRAP: begin
          addr_d = (addr_q == cfg_q.fin) ? cfg_q.beg : addr_inc;
        end
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      vld_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
      dir_q  <= dir_d;
      done_q <= done_d;
      vld_q  <= vld_d;
      run_q  <= run_d;
    end
  end

  assign load_o   = load;
  assign active_o = active;
  assign intv_o   = cfg_q.intv;
  assign addr_o   = addr_q;
  assign vld_o    = vld_q;
  assign done_o   = done_q;

  // R9
  frozen_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(addr_q) && !vld_q));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load) |=> ($stable(addr_q) && done_q));

  // R4
  static_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !walk_mode && !load) |=> $stable(addr_q));

  // R10
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && seg_ok) |-> ((addr_q >= cfg_q.beg) && (addr_q <= cfg_q.fin)));

  // R8
  wrap_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick_i && (cfg_q.mode == MODE_WRAP) && (addr_q == cfg_q.fin))
      |=> (addr_q == cfg_q.beg));

endmodule

// File: rtl/ram_seg_seq.sv
module ram_seg_seq
  import ram_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic              done_o
);

  logic              srst_n;
  seg_cfg_t          dec_cfg;
  logic              tick, load, active;
  logic [INTV_W-1:0] intv;

  seg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (srst_n)
  );

  seg_cfg_decode u_decode (
    .word_i (cfg_i),
    .cfg_o  (dec_cfg)
  );

  seg_step_timer #(.INTV_W(INTV_W)) u_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr_i  (load),
    .run_i  (active),
    .intv_i (intv),
    .tick_o (tick)
  );

  seg_addr_walker u_walker (
    .clk      (clk),
    .rst_n    (srst_n),
    .en_i     (en_i),
    .start_i  (start_i),
    .cfg_i    (dec_cfg),
    .tick_i   (tick),
    .load_o   (load),
    .active_o (active),
    .intv_o   (intv),
    .addr_o   (addr_o),
    .vld_o    (addr_vld_o),
    .done_o   (done_o)
  );

endmodule

// File: tb/ram_seg_seq_bench.sv
module ram_seg_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n, en, start;
  logic [47:0] cfg;
  logic [9:0]  addr;
  logic        vld, done;

  always #5 clk = ~clk;

  ram_seg_seq u_ram_seg_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .start_i    (start),
    .cfg_i      (cfg),
    .addr_o     (addr),
    .addr_vld_o (vld),
    .done_o     (done)
  );

  typedef struct {
    logic [9:0] a;
    logic       d;
    int         gap;
    string      tag;
  } exp_t;

  exp_t  exp_q[$];
  exp_t  cur;
  int    nchk = 0;
  int    nerr = 0;
  int    cyc = 0;
  int    last_cyc = 0;
  bit    finished = 0;
  string phase = "R1";

  task automatic check(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [47:0] mk(int iv, int f, int b, int m, bit junk);
    return {iv[15:0], f[9:0], junk ? 6'h3F : 6'h00, b[9:0], junk ? 3'h7 : 3'h0, m[2:0]};
  endfunction

  task automatic push(int a, bit d, int gap, string tag);
    exp_t e;
    e.a = a[9:0]; e.d = d; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step_edge();
    @(negedge clk); #1;
  endtask

  task automatic launch(logic [47:0] c, string tag);
    phase = tag;
    en = 1'b1; start = 1'b1; cfg = c;
  endtask

  task automatic drain(bit freeze);
    step_edge();
    start = 1'b0;
    while (exp_q.size() != 0) step_edge();
    if (freeze) en = 1'b0;
  endtask

  task automatic idle(int n, int ea, bit ed, string tag);
    for (int i = 0; i < n; i++) step_edge();
    check(addr == ea[9:0], tag, addr, ea);
    check(done == ed, tag, done, ed);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {phase, " unexpected step"}, addr, -1);
      end else begin
        cur = exp_q.pop_front();
        check(addr == cur.a, cur.tag, addr, cur.a);
        check(done == cur.d, {cur.tag, " done"}, done, cur.d);
        if (cur.gap != 0) check((cyc - last_cyc) == cur.gap, "R3 gap", cyc - last_cyc, cur.gap);
      end
      last_cyc = cyc;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; cfg = '0;
    for (int i = 0; i < 4; i++) step_edge();
    // R1 reset state
    check(addr == 10'd0, "R1 addr", addr, 0);
    check(vld == 1'b0, "R1 vld", vld, 0);
    check(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step_edge();
    check(addr == 10'd0 && !vld, "R1 after release", addr, 0);

    // R5 single ramp up, interval 3
    launch(mk(3, 8, 5, 1, 0), "R5");
    push(5, 0, 0, "R2 load");
    push(6, 0, 3, "R5");
    push(7, 0, 3, "R5");
    push(8, 1, 3, "R5 final");
    drain(1);
    en = 1'b1;
    idle(12, 8, 1, "R5 hold");

    // R6 up and down once, interval 0 acts as 1
    launch(mk(0, 12, 10, 2, 0), "R6");
    push(10, 0, 0, "R2 done clear");
    push(11, 0, 1, "R6");
    push(12, 0, 1, "R6");
    push(11, 0, 1, "R6");
    push(10, 1, 1, "R6 back");
    drain(0);
    idle(10, 10, 1, "R6 hold");

    // R7 continuous ping-pong, interval 2
    launch(mk(2, 5, 3, 3, 0), "R7");
    push(3, 0, 0, "R7");
    push(4, 0, 2, "R7");
    push(5, 0, 2, "R7");
    push(4, 0, 2, "R7");
    push(3, 0, 2, "R7");
    push(4, 0, 2, "R7");
    push(5, 0, 2, "R7");
    drain(1);
    // R9 freeze with an ignored start
    phase = "R9";
    for (int i = 0; i < 4; i++) step_edge();
    start = 1'b1; cfg = mk(1, 200, 100, 0, 0);
    step_edge();
    start = 1'b0;
    idle(6, 5, 0, "R9 frozen");
    en = 1'b1;
    push(4, 0, 0, "R9 resume");
    drain(1);
    check(addr == 10'd4, "R9 resumed direction", addr, 4);

    // R8 wrap-around with unused bits set (R11)
    launch(mk(1, 22, 20, 4, 1), "R8");
    push(20, 0, 0, "R11 fields");
    push(21, 0, 1, "R8");
    push(22, 0, 1, "R8");
    push(20, 0, 1, "R8 wrap");
    push(21, 0, 1, "R8");
    push(22, 0, 1, "R8");
    push(20, 0, 1, "R8 wrap");
    drain(1);

    // R4 direct mode
    launch(mk(1, 9, 7, 0, 0), "R4");
    push(7, 0, 0, "R4 direct");
    drain(0);
    idle(15, 7, 0, "R4 direct hold");

    // R4 unused code 110
    launch(mk(1, 30, 25, 6, 0), "R4");
    push(25, 0, 0, "R4 unused code");
    drain(0);
    idle(15, 25, 0, "R4 unused hold");

    // R10 beginning above final
    launch(mk(1, 4, 9, 1, 0), "R10");
    push(9, 0, 0, "R10 load");
    drain(0);
    idle(15, 9, 0, "R10 hold");

    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule